// File: doc/BRIEF.md
# Descriptor Chained Frame Fetcher

At each frame start this block walks the channels of a display DMA engine and loads each enabled channel with its next frame descriptor. The descriptor address for a channel comes from one of two places. A one-shot branch register takes precedence when it is armed. Otherwise the address is the next-descriptor pointer that the previous fetch left behind. Each descriptor is four 32-bit words, read one word at a time over a simple memory read port. A word goes to the next-descriptor, source, frame-ID and command registers in that order.

Before reading, the block checks that the whole descriptor lies inside one of two allowed memory windows. After loading, it checks that the channel has a usable source address. A channel that fails the source check gets a one-cycle bus-error pulse and is skipped for the frame. A branch-status pulse is issued when an armed branch also requests notification. A done pulse follows the last channel. The channel enables come from five separate control inputs. The registers are visible through a word-addressed register port.

The controller has eight states:
- `S_IDLE` waits for `frame_start`, clears every source register and moves to `S_PICK`.
- `S_PICK` goes to `S_RANGE` for an enabled channel and to `S_ADV` for a disabled one. For an enabled channel it also latches the descriptor pointer, disarms the branch and may pulse the branch event.
- `S_RANGE` goes to `S_REQ` when the pointer passes the window check and to `S_CHECK` when it does not.
- `S_REQ` issues one read and always goes to `S_WAIT`.
- `S_WAIT` stays put until `mem_rvalid` arrives. It then goes back to `S_REQ` for the next word, or to `S_CHECK` after the fourth word.
- `S_CHECK` may pulse the bus error and always goes to `S_ADV`.
- `S_ADV` goes to `S_PICK` for the next channel, or to `S_DONE` after the last one.
- `S_DONE` pulses `frame_done` and returns to `S_IDLE`.

Top module: `frame_desc_fetcher`

## Requirements
- R1: After reset, every channel register and branch register reads zero. `busy`, `mem_req`, `frame_done` and both event vectors are low.
- R2: Register map, as byte offsets.
  - Channel c has its registers at 0x200+16*c: word 0x0 is next-descriptor, 0x4 is source, 0x8 is frame ID and 0xC is command.
  - The branch register of channel c is at 0x100+4*c.
  - Only next-descriptor and branch are writable. Writes to source, ID and command have no effect.
  - Any other offset reads zero. `reg_word_addr` carries byte offset bits 11:2.
- R3: A write to next-descriptor stores the value with bits 3:0 forced to zero. A write to a branch register keeps only the bits under mask 0xFFFFFFF3.
- R4: A `frame_start` while idle visits channels 0 to NCH-1 in ascending order and processes only the enabled ones.
  - Channel 0 is enabled by `lcd_enable`.
  - Channel 1 is enabled by `ovl1_enable` OR `dual_panel`.
  - Channels 2 to 4 are enabled by `ovl2_enable`.
  - Channel 5 is enabled by `cursor_enable`.
  - Channel 6 is never enabled.
- R5: For an enabled channel whose branch bit 0 is set, the descriptor pointer is the branch value with bits 3:0 cleared, and branch bit 0 is then cleared. If branch bit 1 is also set, `evt_branch` pulses with only that channel's bit. With bit 0 clear, the stored next-descriptor is the pointer and no branch event occurs.
- R6: A fetch is four single-word reads at pointer, +4, +8 and +12, with at most one read outstanding. The returned words load next-descriptor, source, frame ID and command in that order.
- R7: The fetch happens only if the pointer lies in a window: ptr >= base and ptr+16 <= base+size. The two windows are 0x1000_0000/0x1_0000 and 0x2000_0000/0x1000. Otherwise no read is issued for that channel.
- R8: Every channel's source register is cleared when a frame starts, whether or not the channel is enabled in that frame.
- R9: After its fetch step, an enabled channel pulses its `evt_bus_error` bit if its source is zero or lies outside every window. The window test here is base <= src <= base+size.
- R10: `frame_done` is a one-cycle pulse after the last channel. `busy` is high from the cycle after an accepted `frame_start` until `frame_done`. A `frame_start` while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Begin descriptor sequencing for a new frame |
| lcd_enable | input | 1 | Base plane enable (channel 0) |
| dual_panel | input | 1 | Second panel enable (channel 1) |
| ovl1_enable | input | 1 | First overlay enable (channel 1) |
| ovl2_enable | input | 1 | Second overlay enable (channels 2 to 4) |
| cursor_enable | input | 1 | Cursor plane enable (channel 5) |
| reg_we | input | 1 | Register write strobe |
| reg_word_addr | input | 10 | Register byte offset bits 11:2 |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| mem_req | output | 1 | One-cycle descriptor word read request |
| mem_addr | output | 32 | Byte address of the requested word |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| evt_branch | output | NCH | Branch-status pulse, one bit per channel |
| evt_bus_error | output | NCH | Bus-error pulse, one bit per channel |
| frame_done | output | 1 | Pulse after the last channel |
| busy | output | 1 | Sequencing in progress |

## Verification
A wrong channel counter or pointer latch shows up at the memory port on the very next `S_REQ` cycle. The read address or the order of reads then no longer matches the model. A missed branch disarm or source clear is invisible until the following frame, when an extra branch pulse or a stale source readback exposes it. The bench keeps an ordered list of expected port activity and compares it every cycle, so a misplaced event is caught in the cycle it appears. Full register readback after each frame covers the loaded state.

// File: rtl/dff_pkg.sv
`timescale 1ns/1ps
package dff_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PICK,
        S_RANGE,
        S_REQ,
        S_WAIT,
        S_CHECK,
        S_ADV,
        S_DONE
    } fetch_state_e;

    typedef struct packed {
        logic lcd_en;
        logic dual_panel;
        logic ovl1_en;
        logic ovl2_en;
        logic cursor_en;
    } chan_ctl_t;

    localparam logic [31:0] BRANCH_KEEP = 32'hFFFF_FFF3;

    // Enable source of each channel
    function automatic logic chan_enabled(input int ch, input chan_ctl_t c);
        case (ch)
            0:       return c.lcd_en;
            1:       return c.ovl1_en | c.dual_panel;
            2, 3, 4: return c.ovl2_en;
            5:       return c.cursor_en;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/dff_addr_window.sv
`timescale 1ns/1ps
module dff_addr_window #(
    parameter logic [31:0] A_BASE = 32'h1000_0000,
    parameter logic [31:0] A_SIZE = 32'h0001_0000,
    parameter logic [31:0] B_BASE = 32'h2000_0000,
    parameter logic [31:0] B_SIZE = 32'h0000_1000,
    parameter int          SPAN   = 16
) (
    input  logic [31:0] addr,
    output logic        hit
);
    localparam logic [32:0] A_END = {1'b0, A_BASE} + {1'b0, A_SIZE};
    localparam logic [32:0] B_END = {1'b0, B_BASE} + {1'b0, B_SIZE};
    localparam logic [32:0] SPAN_W = 33'(SPAN);

    logic [32:0] a_ext;
    logic [32:0] a_last;
    logic        in_a;
    logic        in_b;

    assign a_ext  = {1'b0, addr};
    assign a_last = a_ext + SPAN_W;
    assign in_a   = (a_ext >= {1'b0, A_BASE}) && (a_last <= A_END);
    assign in_b   = (a_ext >= {1'b0, B_BASE}) && (a_last <= B_END);
    assign hit    = in_a | in_b;

endmodule

// File: rtl/dff_chan_regs.sv
`timescale 1ns/1ps
module dff_chan_regs #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_desc_we,
    input  logic          bus_branch_we,
    input  logic [DW-1:0] bus_wdata,
    input  logic          clr_src,
    input  logic          disarm_branch,
    input  logic [3:0]    ld_we,
    input  logic [DW-1:0] ld_data,
    output logic [DW-1:0] desc_q,
    output logic [DW-1:0] src_q,
    output logic [DW-1:0] id_q,
    output logic [DW-1:0] cmd_q,
    output logic [DW-1:0] branch_q
);
    import dff_pkg::*;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            desc_q   <= '0;
            src_q    <= '0;
            id_q     <= '0;
            cmd_q    <= '0;
            branch_q <= '0;
        end else begin
            if (clr_src)       src_q       <= '0;
            if (disarm_branch) branch_q[0] <= 1'b0;
            if (ld_we[0])      desc_q      <= ld_data;
            if (ld_we[1])      src_q       <= ld_data;
            if (ld_we[2])      id_q        <= ld_data;
            if (ld_we[3])      cmd_q       <= ld_data;
            // register port has the last word
            if (bus_desc_we)   desc_q      <= {bus_wdata[DW-1:4], 4'b0000};
            if (bus_branch_we) branch_q    <= bus_wdata & BRANCH_KEEP[DW-1:0];
        end
    end

    p_desc_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_desc_we |=> (desc_q[3:0] == 4'b0000));

    p_branch_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_branch_we |=> (branch_q[3:2] == 2'b00));

endmodule

// File: rtl/frame_desc_fetcher.sv
`timescale 1ns/1ps
module frame_desc_fetcher
    import dff_pkg::*;
#(
    parameter int          NCH        = 7,
    parameter logic [31:0] WIN_A_BASE = 32'h1000_0000,
    parameter logic [31:0] WIN_A_SIZE = 32'h0001_0000,
    parameter logic [31:0] WIN_B_BASE = 32'h2000_0000,
    parameter logic [31:0] WIN_B_SIZE = 32'h0000_1000
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           frame_start,
    input  logic           lcd_enable,
    input  logic           dual_panel,
    input  logic           ovl1_enable,
    input  logic           ovl2_enable,
    input  logic           cursor_enable,
    input  logic           reg_we,
    input  logic [9:0]     reg_word_addr,
    input  logic [31:0]    reg_wdata,
    output logic [31:0]    reg_rdata,
    output logic           mem_req,
    output logic [31:0]    mem_addr,
    input  logic           mem_rvalid,
    input  logic [31:0]    mem_rdata,
    output logic [NCH-1:0] evt_branch,
    output logic [NCH-1:0] evt_bus_error,
    output logic           frame_done,
    output logic           busy
);
    localparam int CW    = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int NSLOT = 1 << CW;
    localparam logic [CW-1:0] LAST_CH = CW'(NCH - 1);

    fetch_state_e  state_q, state_d;
    logic [CW-1:0] ch_q;
    logic [1:0]    word_q;
    logic [31:0]   ptr_q;

    chan_ctl_t        ctl;
    logic [NSLOT-1:0] en_vec;
    logic [31:0]      desc_a [NSLOT];
    logic [31:0]      src_a  [NSLOT];
    logic [31:0]      id_a   [NSLOT];
    logic [31:0]      cmd_a  [NSLOT];
    logic [31:0]      br_a   [NSLOT];

    logic        sel_chan, sel_br;
    logic        cur_en, take_branch, desc_ok, src_in, src_ok;
    logic [31:0] cur_br, cur_desc, cur_src;
    logic        ld_strobe;

    assign ctl = '{lcd_en: lcd_enable, dual_panel: dual_panel, ovl1_en: ovl1_enable,
                   ovl2_en: ovl2_enable, cursor_en: cursor_enable};

    assign sel_chan    = (reg_word_addr[9:6] == 4'h2);
    assign sel_br      = (reg_word_addr[9:6] == 4'h1);
    assign cur_en      = en_vec[ch_q];
    assign cur_br      = br_a[ch_q];
    assign cur_desc    = desc_a[ch_q];
    assign cur_src     = src_a[ch_q];
    assign take_branch = (state_q == S_PICK) && cur_en && cur_br[0];
    assign ld_strobe   = (state_q == S_WAIT) && mem_rvalid;
    assign src_ok      = src_in && (cur_src != 32'd0);

    genvar g;
    generate
        for (g = 0; g < NSLOT; g++) begin : g_chan
            if (g < NCH) begin : g_live
                logic [3:0] ld_we;
                assign en_vec[g] = chan_enabled(g, ctl);
                assign ld_we = (ld_strobe && (ch_q == CW'(g))) ? (4'b0001 << word_q) : 4'b0000;
                dff_chan_regs #(.DW(32)) u_regs (
                    .clk           (clk),
                    .rst_n         (rst_n),
                    .bus_desc_we   (reg_we && sel_chan && (reg_word_addr[5:2] == 4'(g))
                                    && (reg_word_addr[1:0] == 2'd0)),
                    .bus_branch_we (reg_we && sel_br && (reg_word_addr[5:0] == 6'(g))),
                    .bus_wdata     (reg_wdata),
                    .clr_src       ((state_q == S_IDLE) && frame_start),
                    .disarm_branch (take_branch && (ch_q == CW'(g))),
                    .ld_we         (ld_we),
                    .ld_data       (mem_rdata),
                    .desc_q        (desc_a[g]),
                    .src_q         (src_a[g]),
                    .id_q          (id_a[g]),
                    .cmd_q         (cmd_a[g]),
                    .branch_q      (br_a[g])
                );
            end else begin : g_pad
                assign en_vec[g] = 1'b0;
                assign desc_a[g] = '0;
                assign src_a[g]  = '0;
                assign id_a[g]   = '0;
                assign cmd_a[g]  = '0;
                assign br_a[g]   = '0;
            end
        end
    endgenerate

    dff_addr_window #(.A_BASE(WIN_A_BASE), .A_SIZE(WIN_A_SIZE), .B_BASE(WIN_B_BASE),
                      .B_SIZE(WIN_B_SIZE), .SPAN(16)) u_desc_win (
        .addr (ptr_q),
        .hit  (desc_ok)
    );

    dff_addr_window #(.A_BASE(WIN_A_BASE), .A_SIZE(WIN_A_SIZE), .B_BASE(WIN_B_BASE),
                      .B_SIZE(WIN_B_SIZE), .SPAN(0)) u_src_win (
        .addr (cur_src),
        .hit  (src_in)
    );

    // State register and sequencing datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            ch_q    <= '0;
            word_q  <= '0;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                S_IDLE:  if (frame_start) ch_q <= '0;
                S_PICK:  ptr_q <= cur_br[0] ? {cur_br[31:4], 4'b0000} : cur_desc;
                S_RANGE: word_q <= '0;
                S_WAIT:  if (mem_rvalid) word_q <= word_q + 2'd1;
                S_ADV:   if (ch_q != LAST_CH) ch_q <= ch_q + 1'b1;
                default: ;
            endcase
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (frame_start) state_d = S_PICK;
            S_PICK:  state_d = cur_en ? S_RANGE : S_ADV;
            S_RANGE: state_d = desc_ok ? S_REQ : S_CHECK;
            S_REQ:   state_d = S_WAIT;
            S_WAIT:  if (mem_rvalid) state_d = (word_q == 2'd3) ? S_CHECK : S_REQ;
            S_CHECK: state_d = S_ADV;
            S_ADV:   state_d = (ch_q == LAST_CH) ? S_DONE : S_PICK;
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        mem_req       = (state_q == S_REQ);
        mem_addr      = ptr_q + {28'd0, word_q, 2'b00};
        frame_done    = (state_q == S_DONE);
        busy          = (state_q != S_IDLE);
        evt_branch    = (take_branch && cur_br[1]) ? (NCH'(1) << ch_q) : '0;
        evt_bus_error = ((state_q == S_CHECK) && !src_ok) ? (NCH'(1) << ch_q) : '0;
    end

    // Register read mux
    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NCH; i++) begin
            if (sel_chan && (reg_word_addr[5:2] == 4'(i))) begin
                case (reg_word_addr[1:0])
                    2'd0: reg_rdata = desc_a[i];
                    2'd1: reg_rdata = src_a[i];
                    2'd2: reg_rdata = id_a[i];
                    2'd3: reg_rdata = cmd_a[i];
                endcase
            end
            if (sel_br && (reg_word_addr[5:0] == 6'(i))) reg_rdata = br_a[i];
        end
    end

    p_single_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> (!frame_done && !busy));

    p_start_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && frame_start) |=> busy);

    p_err_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(evt_bus_error));

    p_branch_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(evt_branch));

    p_req_when_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

endmodule

// File: tb/sim_frame_desc_fetcher.sv
`timescale 1ns/1ps
module sim_frame_desc_fetcher;
    localparam int NCH = 7;
    localparam longint unsigned WA = 64'h1000_0000, WA_SZ = 64'h0001_0000;
    localparam longint unsigned WB = 64'h2000_0000, WB_SZ = 64'h0000_1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_start = 1'b0;
    logic lcd_enable = 1'b0, dual_panel = 1'b0, ovl1_enable = 1'b0;
    logic ovl2_enable = 1'b0, cursor_enable = 1'b0;
    logic reg_we = 1'b0;
    logic [9:0] reg_word_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic mem_req;
    logic [31:0] mem_addr;
    logic mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [NCH-1:0] evt_branch, evt_bus_error;
    logic frame_done, busy;

    int nvec = 0;
    int nfail = 0;
    bit finished = 0;
    bit done_seen = 0;

    logic [31:0] mem_img [logic [31:0]];
    logic [31:0] m_desc [NCH];
    logic [31:0] m_src  [NCH];
    logic [31:0] m_id   [NCH];
    logic [31:0] m_cmd  [NCH];
    logic [31:0] m_br   [NCH];
    int          q_kind [$];
    logic [31:0] q_val  [$];

    frame_desc_fetcher #(.NCH(NCH)) u0 (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .lcd_enable(lcd_enable), .dual_panel(dual_panel), .ovl1_enable(ovl1_enable),
        .ovl2_enable(ovl2_enable), .cursor_enable(cursor_enable),
        .reg_we(reg_we), .reg_word_addr(reg_word_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .evt_branch(evt_branch),
        .evt_bus_error(evt_bus_error), .frame_done(frame_done), .busy(busy)
    );

    initial forever #10 clk = ~clk;

    function automatic logic [31:0] rd_mem(input logic [31:0] a);
        if (mem_img.exists(a)) return mem_img[a];
        return 32'd0;
    endfunction

    function automatic bit ch_en(input int c);
        case (c)
            0: return lcd_enable;
            1: return ovl1_enable | dual_panel;
            2, 3, 4: return ovl2_enable;
            5: return cursor_enable;
            default: return 1'b0;
        endcase
    endfunction

    function automatic bit desc_in_win(input logic [31:0] p);
        longint unsigned v = longint'(p);
        return (v >= WA && v + 16 <= WA + WA_SZ) || (v >= WB && v + 16 <= WB + WB_SZ);
    endfunction

    function automatic bit src_good(input logic [31:0] s);
        longint unsigned v = longint'(s);
        if (s == 32'd0) return 1'b0;
        return (v >= WA && v <= WA + WA_SZ) || (v >= WB && v <= WB + WB_SZ);
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic expect_act(input int kind, input logic [31:0] val, input string tag);
        nvec++;
        if (q_kind.size() == 0) begin
            nfail++;
            $display("FAIL %s unexpected activity: actual kind %0d value %h expected none",
                     tag, kind, val);
        end else begin
            int ek = q_kind.pop_front();
            logic [31:0] ev = q_val.pop_front();
            if (ek != kind || ev !== val) begin
                nfail++;
                $display("FAIL %s activity: actual kind %0d value %h expected kind %0d value %h",
                         tag, kind, val, ek, ev);
            end
        end
    endtask

    // Per-clock comparison and memory responder
    initial begin
        int pend = 0;
        logic [31:0] pend_addr = '0;
        forever begin
            @(negedge clk);
            if (pend > 0) begin
                pend--;
                if (pend == 0) begin
                    mem_rvalid = 1'b1;
                    mem_rdata  = rd_mem(pend_addr);
                end else mem_rvalid = 1'b0;
            end else mem_rvalid = 1'b0;
            if (mem_req === 1'b1) begin
                expect_act(0, mem_addr, "R6");
                pend_addr = mem_addr;
                pend = 1 + int'(mem_addr[2]);
            end
            if (|evt_branch === 1'b1) expect_act(1, 32'(evt_branch), "R5");
            if (|evt_bus_error === 1'b1) expect_act(2, 32'(evt_bus_error), "R9");
            if (frame_done === 1'b1) begin
                expect_act(3, 32'd0, "R10");
                done_seen = 1;
            end
        end
    end

    task automatic put_desc(input logic [31:0] a, input logic [31:0] w0, input logic [31:0] w1,
                            input logic [31:0] w2, input logic [31:0] w3);
        mem_img[a] = w0;
        mem_img[a + 4] = w1;
        mem_img[a + 8] = w2;
        mem_img[a + 12] = w3;
    endtask

    task automatic wr(input logic [11:0] off, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1;
        reg_word_addr = off[11:2];
        reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [11:0] off, input logic [31:0] exp, input string tag,
                          input string what);
        @(negedge clk);
        reg_word_addr = off[11:2];
        #1;
        chk(tag, what, reg_rdata, exp);
    endtask

    task automatic wr_desc(input int c, input logic [31:0] d);
        wr(12'(12'h200 + 16 * c), d);
        m_desc[c] = {d[31:4], 4'b0000};
    endtask

    task automatic wr_branch(input int c, input logic [31:0] d);
        wr(12'(12'h100 + 4 * c), d);
        m_br[c] = d & 32'hFFFF_FFF3;
    endtask

    task automatic chk_all(input string tag);
        for (int c = 0; c < NCH; c++) begin
            rd_chk(12'(12'h200 + 16 * c), m_desc[c], tag, $sformatf("desc ch%0d", c));
            rd_chk(12'(12'h204 + 16 * c), m_src[c],  tag, $sformatf("src ch%0d", c));
            rd_chk(12'(12'h208 + 16 * c), m_id[c],   tag, $sformatf("id ch%0d", c));
            rd_chk(12'(12'h20C + 16 * c), m_cmd[c],  tag, $sformatf("cmd ch%0d", c));
            rd_chk(12'(12'h100 + 4 * c),  m_br[c],   tag, $sformatf("branch ch%0d", c));
        end
        chk(tag, "busy", 32'(busy), 32'd0);
    endtask

    // Behavioural frame model: expected activity list and new register values
    task automatic model_frame();
        for (int c = 0; c < NCH; c++) m_src[c] = 32'd0;
        for (int c = 0; c < NCH; c++) begin
            logic [31:0] p;
            if (!ch_en(c)) continue;
            if (m_br[c][0]) begin
                p = m_br[c] & 32'hFFFF_FFF0;
                m_br[c][0] = 1'b0;
                if (m_br[c][1]) begin
                    q_kind.push_back(1);
                    q_val.push_back(32'd1 << c);
                end
            end else p = m_desc[c];
            if (desc_in_win(p)) begin
                for (int w = 0; w < 4; w++) begin
                    q_kind.push_back(0);
                    q_val.push_back(p + 32'(4 * w));
                end
                m_desc[c] = rd_mem(p);
                m_src[c]  = rd_mem(p + 4);
                m_id[c]   = rd_mem(p + 8);
                m_cmd[c]  = rd_mem(p + 12);
            end
            if (!src_good(m_src[c])) begin
                q_kind.push_back(2);
                q_val.push_back(32'd1 << c);
            end
        end
        q_kind.push_back(3);
        q_val.push_back(32'd0);
    endtask

    task automatic run_frame(input bit poke_mid, input string tag);
        model_frame();
        done_seen = 0;
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        if (poke_mid) begin
            repeat (3) @(negedge clk);
            frame_start = 1'b1;
            @(negedge clk);
            frame_start = 1'b0;
        end
        while (!done_seen) @(negedge clk);
        repeat (4) @(negedge clk);
        chk("R10", "pending activity", 32'(q_kind.size()), 32'd0);
        chk_all(tag);
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            nfail++;
            $display("FAIL R10 watchdog: actual hung expected frame completion");
            summary();
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < NCH; c++) begin
            m_desc[c] = '0; m_src[c] = '0; m_id[c] = '0; m_cmd[c] = '0; m_br[c] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1", "mem_req", 32'(mem_req), 32'd0);
        chk("R1", "frame_done", 32'(frame_done), 32'd0);
        chk("R1", "evt_branch", 32'(evt_branch), 32'd0);
        chk("R1", "evt_bus_error", 32'(evt_bus_error), 32'd0);
        chk_all("R1");

        // R3: write masking
        wr_desc(0, 32'h1000_0013);
        rd_chk(12'h200, 32'h1000_0010, "R3", "desc align");
        wr_branch(1, 32'hFFFF_FFFF);
        rd_chk(12'h104, 32'hFFFF_FFF3, "R3", "branch mask");
        wr_branch(1, 32'h0);
        // R2: read-only words and unmapped offsets
        wr(12'h204, 32'hDEAD_BEEF);
        wr(12'h208, 32'h1234_5678);
        wr(12'h20C, 32'hCAFE_F00D);
        rd_chk(12'h204, 32'h0, "R2", "src not writable");
        rd_chk(12'h208, 32'h0, "R2", "id not writable");
        rd_chk(12'h20C, 32'h0, "R2", "cmd not writable");
        rd_chk(12'h3F0, 32'h0, "R2", "unmapped read");
        rd_chk(12'h270, 32'h0, "R2", "absent channel read");

        // Frame A: base plane only (R4, R6)
        put_desc(32'h1000_0010, 32'h1000_0044, 32'h1000_2000, 32'h0000_00A5, 32'h0400_0100);
        lcd_enable = 1'b1;
        run_frame(1'b0, "R4");

        // Frame B: branch with notify, window edges, bus errors (R5, R7, R9)
        wr_branch(0, 32'h1000_0083);
        put_desc(32'h1000_0080, 32'h1000_0010, 32'h1000_3000, 32'h11, 32'h0020_0004);
        wr_desc(2, 32'h2000_0000);
        put_desc(32'h2000_0000, 32'h2000_0000, 32'h2000_1000, 32'h22, 32'h0400_0000);
        wr_desc(3, 32'h1000_FFF0);
        put_desc(32'h1000_FFF0, 32'h0, 32'h1001_0001, 32'h33, 32'h0);
        wr_desc(4, 32'h3000_0000);
        wr_desc(5, 32'h1000_0100);
        put_desc(32'h1000_0100, 32'h1000_0100, 32'h0, 32'h55, 32'h0);
        ovl2_enable = 1'b1;
        cursor_enable = 1'b1;
        run_frame(1'b0, "R7");

        // Frame C: branch without notify on ch1, late start ignored, sources cleared (R5, R8, R10)
        lcd_enable = 1'b0; ovl2_enable = 1'b0; cursor_enable = 1'b0;
        dual_panel = 1'b1;
        wr_branch(1, 32'h1000_0201);
        put_desc(32'h1000_0200, 32'h1000_0300, 32'h1000_4000, 32'h77, 32'h0400_0040);
        run_frame(1'b1, "R8");

        // Frame D: nothing enabled, only the done pulse (R4)
        dual_panel = 1'b0;
        run_frame(1'b0, "R4");

        // Frame E: channel 1 through overlay-1, stored pointer, empty source (R6, R9)
        ovl1_enable = 1'b1;
        run_frame(1'b0, "R9");

        finished = 1;
        summary();
        $finish;
    end

endmodule